// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a core that runs several hardware threads at once, only one thread may retire instructions in a given cycle. This block decides which one. Each cycle it looks at every thread's state: whether the thread is active, whether the instruction at the head of its reorder buffer is ready to retire, whether its buffer is empty, and the sequence number of its head instruction. From these it names one thread, or reports that none can proceed.

A static mode input selects one of two policies. In rotating mode the block keeps an ordered list of thread indices. It grants the first qualifying thread in that list and moves the winner to the back. In age mode it grants the qualifying thread whose head instruction is oldest. When exactly one thread is active, the block skips the policy and grants that thread if its head is ready. The grant is combinational from the current inputs. Only the rotating list is state, and it changes only on a clock edge that follows a rotating-mode grant.

Top module: `csel_commit_sel`

## Requirements
- R1: When no thread qualifies under the path in use, `grant_valid_o` is 0 and `grant_tid_o` carries the reserved code of all ones (3'b111 with 4 threads). When there is a grant, `grant_valid_o` is 1 and `grant_tid_o` holds the thread index, which is below the thread count.
- R2: In rotating mode (`mode_i` = 0) with two or more active threads, the grant goes to the first thread in list order whose `active_i` and `head_rdy_i` bits are both 1.
- R3: After a rotating-mode grant, the winner is removed from its position in the list and placed at the back on the next rising clock edge. The other threads keep their relative order.
- R4: In rotating mode, a cycle without a grant leaves the list unchanged.
- R5: In age mode (`mode_i` = 1) with two or more active threads, only threads that are active, have a ready head and have a non-empty buffer are candidates. The grant goes to the candidate with the smallest head sequence number, compared as an unsigned value. Thread t's sequence number is `head_seq_i[16*t +: 16]`.
- R6: In age mode, when candidates share the smallest sequence number, the lowest thread index wins.
- R7: With exactly one active thread, that thread is granted whenever its head is ready, in either mode and whatever its empty bit says. If its head is not ready there is no grant. Such a cycle leaves the rotating list unchanged.
- R8: Reset (`rst_n` low) puts the list in ascending order 0, 1, 2, 3, with thread 0 at the front.
- R9: The grant follows input changes within the same cycle, with no clock edge in between.
- R10: Grants in age mode leave the rotating list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Policy select: 0 rotating, 1 age |
| active_i | input | 4 | Per-thread active bit |
| head_rdy_i | input | 4 | Per-thread head-ready bit |
| buf_empty_i | input | 4 | Per-thread reorder-buffer empty bit |
| head_seq_i | input | 64 | Head sequence numbers, 16 bits per thread, thread 0 in the low bits |
| grant_valid_o | output | 1 | A thread is granted this cycle |
| grant_tid_o | output | 3 | Granted thread index, or all ones when there is no grant |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Rotation.** Grants repeat over many cycles with only some threads ready. A selector that rotated from the grant position, rather than moving the winner to the back, would soon pick a different thread than the list predicts.
- **Age mode.** Sequence numbers are drawn from a small range so that ties are frequent. An empty thread holding the smallest number is set up on purpose. A strict-versus-non-strict slip would favour the higher index in a tie, and a missing empty check would grant a thread with nothing to retire.
- **Single active thread.** This path is driven with the empty bit set and in both modes. A design that sent it through the policy would refuse the grant in age mode, and one that rotated the list here would shift every later rotating grant.
- **No grant.** The reserved output code is checked whenever nothing qualifies.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_AGE    = 1'b1
  } csel_mode_e;

  // Count of set bits in a 32-bit thread vector.
  function automatic int unsigned csel_popcount(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // Strict "older than": on a tie the earlier scanned index keeps the win.
  function automatic logic csel_older(input logic [31:0] a, input logic [31:0] b);
    return a < b;
  endfunction

endpackage

// File: rtl/csel_prio_list.sv
module csel_prio_list #(
  parameter int N  = 4,
  localparam int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig_i,
  input  logic          adv_i,
  output logic          hit_o,
  output logic [TW-1:0] pick_o,
  output logic [N*TW-1:0] list_o
);

  logic [TW-1:0] q [N];
  logic [TW-1:0] pos;

  // Front-to-back scan for the first eligible thread.
  always_comb begin
    hit_o  = 1'b0;
    pick_o = '0;
    pos    = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit_o && elig_i[q[i]]) begin
        hit_o  = 1'b1;
        pick_o = q[i];
        pos    = TW'(i);
      end
    end
  end

  // Remove the winner from its slot and append it at the back.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) q[i] <= TW'(i);
    end else if (adv_i && hit_o) begin
      for (int i = 0; i < N - 1; i++) begin
        if (TW'(i) >= pos) q[i] <= q[i+1];
      end
      q[N-1] <= pick_o;
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_flat
      assign list_o[g*TW +: TW] = q[g];
    end
  endgenerate

endmodule

// File: rtl/csel_age_pick.sv
module csel_age_pick #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  localparam int TW   = $clog2(N)
) (
  input  logic [N-1:0]       cand_i,
  input  logic [N*SEQ_W-1:0] seq_i,
  output logic               hit_o,
  output logic [TW-1:0]      pick_o
);

  import csel_pkg::*;

  logic [SEQ_W-1:0] best;

  always_comb begin
    hit_o  = 1'b0;
    pick_o = '0;
    best   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i]) begin
        if (!hit_o || csel_older(32'(seq_i[i*SEQ_W +: SEQ_W]), 32'(best))) begin
          hit_o  = 1'b1;
          pick_o = TW'(i);
          best   = seq_i[i*SEQ_W +: SEQ_W];
        end
      end
    end
  end

endmodule

// File: rtl/csel_commit_sel.sv
module csel_commit_sel #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  localparam int TW   = $clog2(N),
  localparam int IDW  = TW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_i,
  input  logic [N-1:0]       active_i,
  input  logic [N-1:0]       head_rdy_i,
  input  logic [N-1:0]       buf_empty_i,
  input  logic [N*SEQ_W-1:0] head_seq_i,
  output logic               grant_valid_o,
  output logic [IDW-1:0]     grant_tid_o
);

  import csel_pkg::*;

  localparam logic [IDW-1:0] TID_NONE = '1;

  logic            solo;
  logic [TW-1:0]   solo_idx;
  logic            rot_hit, age_hit;
  logic [TW-1:0]   rot_pick, age_pick;
  logic            rot_adv;
  logic [N*TW-1:0] prio_list;
  logic [N-1:0]    rot_elig, age_cand;

  assign rot_elig = active_i & head_rdy_i;
  assign age_cand = active_i & head_rdy_i & ~buf_empty_i;
  assign solo     = (csel_popcount(32'(active_i)) == 1);

  always_comb begin
    solo_idx = '0;
    for (int i = 0; i < N; i++) if (active_i[i]) solo_idx = TW'(i);
  end

  assign rot_adv = !solo && (csel_mode_e'(mode_i) == MODE_ROTATE);

  csel_prio_list #(.N(N)) u_list (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig_i (rot_elig),
    .adv_i  (rot_adv),
    .hit_o  (rot_hit),
    .pick_o (rot_pick),
    .list_o (prio_list)
  );

  csel_age_pick #(.N(N), .SEQ_W(SEQ_W)) u_age (
    .cand_i (age_cand),
    .seq_i  (head_seq_i),
    .hit_o  (age_hit),
    .pick_o (age_pick)
  );

  always_comb begin
    grant_valid_o = 1'b0;
    grant_tid_o   = TID_NONE;
    if (solo) begin
      if (head_rdy_i[solo_idx]) begin
        grant_valid_o = 1'b1;
        grant_tid_o   = {1'b0, solo_idx};
      end
    end else if (csel_mode_e'(mode_i) == MODE_ROTATE) begin
      if (rot_hit) begin
        grant_valid_o = 1'b1;
        grant_tid_o   = {1'b0, rot_pick};
      end
    end else if (age_hit) begin
      grant_valid_o = 1'b1;
      grant_tid_o   = {1'b0, age_pick};
    end
  end

endmodule

// File: rtl/csel_commit_sel_chk.sv
module csel_commit_sel_chk #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  localparam int TW   = $clog2(N),
  localparam int IDW  = TW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_i,
  input logic [N-1:0]    active_i,
  input logic [N-1:0]    head_rdy_i,
  input logic [N-1:0]    buf_empty_i,
  input logic            grant_valid_o,
  input logic [IDW-1:0]  grant_tid_o,
  input logic            rot_adv,
  input logic [N*TW-1:0] prio_list
);

  logic [TW-1:0] gidx;
  logic          multi;
  assign gidx  = grant_tid_o[TW-1:0];
  assign multi = $countones(active_i) > 1;

  AST_NONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o |-> grant_tid_o == '1); // R1

  AST_GRANT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> (grant_tid_o[IDW-1] == 1'b0) && active_i[gidx] && head_rdy_i[gidx]); // R2

  AST_AGE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid_o && mode_i && multi) |-> !buf_empty_i[gidx]); // R5

  AST_ROT_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_adv && grant_valid_o) |=> prio_list[(N-1)*TW +: TW] == $past(gidx)); // R3

  AST_ROT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_adv && !grant_valid_o) |=> prio_list == $past(prio_list)); // R4

  AST_AGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i || !multi) |=> prio_list == $past(prio_list)); // R10

endmodule

bind csel_commit_sel csel_commit_sel_chk #(.N(N), .SEQ_W(SEQ_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .active_i      (active_i),
  .head_rdy_i    (head_rdy_i),
  .buf_empty_i   (buf_empty_i),
  .grant_valid_o (grant_valid_o),
  .grant_tid_o   (grant_tid_o),
  .rot_adv       (rot_adv),
  .prio_list     (prio_list)
);

// File: tb/csel_commit_sel_tb.sv
`timescale 1ns/1ps
module csel_commit_sel_tb;

  localparam int N = 4;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_i = 1'b0;
  logic [N-1:0]  active_i = '0, head_rdy_i = '0, buf_empty_i = '0;
  logic [N*SW-1:0] head_seq_i = '0;
  logic          grant_valid_o;
  logic [2:0]    grant_tid_o;

  int n_chk = 0, n_bad = 0;
  int mq [N];
  bit done = 0;

  always #2.5 clk = ~clk;

  csel_commit_sel u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .active_i(active_i),
    .head_rdy_i(head_rdy_i), .buf_empty_i(buf_empty_i), .head_seq_i(head_seq_i),
    .grant_valid_o(grant_valid_o), .grant_tid_o(grant_tid_o)
  );

  // Reference selection; returns 7 for no grant, sets rot when the list must rotate.
  function automatic int ref_pick(output bit rot, output string tag);
    int cnt, idx, best;
    rot = 0; cnt = 0; idx = 0;
    for (int i = 0; i < N; i++) if (active_i[i]) begin cnt++; idx = i; end
    if (cnt == 1) begin
      tag = "R7";
      return head_rdy_i[idx] ? idx : 7;
    end
    if (!mode_i) begin
      tag = "R2";
      for (int k = 0; k < N; k++)
        if (active_i[mq[k]] && head_rdy_i[mq[k]]) begin rot = 1; return mq[k]; end
      tag = "R1";
      return 7;
    end
    tag = "R5"; best = -1;
    for (int i = 0; i < N; i++)
      if (active_i[i] && head_rdy_i[i] && !buf_empty_i[i])
        if (best < 0 || head_seq_i[i*SW +: SW] < head_seq_i[best*SW +: SW]) best = i;
    if (best < 0) begin tag = "R1"; return 7; end
    return best;
  endfunction

  task automatic check(input int exp, input string tag);
    n_chk++;
    if (grant_tid_o !== 3'(exp) || grant_valid_o !== (exp != 7)) begin
      n_bad++;
      $display("FAIL %s: tid=%0d valid=%0b expected tid=%0d valid=%0b",
               tag, grant_tid_o, grant_valid_o, exp, exp != 7);
    end
  endtask

  task automatic step(input logic m, input logic [3:0] a, input logic [3:0] r,
                      input logic [3:0] e, input logic [63:0] s, input string tag);
    bit rot; string t; int exp, p;
    @(negedge clk);
    mode_i = m; active_i = a; head_rdy_i = r; buf_empty_i = e; head_seq_i = s;
    #1;
    exp = ref_pick(rot, t);
    check(exp, (tag == "") ? t : tag);
    @(posedge clk);
    if (rot) begin
      p = 0;
      for (int k = 0; k < N; k++) if (mq[k] == exp) p = k;
      for (int k = p; k < N - 1; k++) mq[k] = mq[k+1];
      mq[N-1] = exp;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_c0de);
    for (int k = 0; k < N; k++) mq[k] = k;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R8: ascending order after reset, each grant moves winner back (R3)
    step(0, 4'hF, 4'hF, 4'h0, '0, "R8");
    step(0, 4'hF, 4'hF, 4'h0, '0, "R3");
    step(0, 4'hF, 4'b0100, 4'h0, '0, "R3");
    step(0, 4'hF, 4'hF, 4'h0, '0, "R3");
    // R4: idle cycle keeps list
    step(0, 4'hF, 4'h0, 4'h0, '0, "R4");
    step(0, 4'hF, 4'hF, 4'h0, '0, "R4");
    // R1: nothing active
    step(0, 4'h0, 4'hF, 4'h0, '0, "R1");
    step(1, 4'h0, 4'hF, 4'h0, '0, "R1");
    // R5: thread 0 oldest but empty, thread 2 next oldest
    step(1, 4'hF, 4'hF, 4'b0001, {16'd40, 16'd9, 16'd30, 16'd1}, "R5");
    // R6: tie between threads 1 and 3
    step(1, 4'hF, 4'b1010, 4'h0, {16'd5, 16'd7, 16'd5, 16'd2}, "R6");
    // R10: age grants, then rotating continues from unchanged list
    step(1, 4'hF, 4'hF, 4'h0, {16'd4, 16'd3, 16'd2, 16'd1}, "R10");
    step(0, 4'hF, 4'hF, 4'h0, '0, "R10");
    // R7: single active thread, empty bit set, both modes; list untouched
    step(1, 4'b0100, 4'b0100, 4'b0100, '0, "R7");
    step(0, 4'b0100, 4'b0100, 4'b0100, '0, "R7");
    step(0, 4'b0100, 4'b1011, 4'b0000, '0, "R7");
    step(0, 4'hF, 4'hF, 4'h0, '0, "R7");
    // R9: output responds within the cycle to a new input pattern
    step(0, 4'hF, 4'b1000, 4'h0, '0, "R9");
    // Random mix, small sequence range for frequent ties
    for (int it = 0; it < 4000; it++) begin
      logic [63:0] s;
      for (int t = 0; t < N; t++) s[t*16 +: 16] = 16'($urandom_range(0, 5));
      if (it % 7 == 0) s[15:0] = 16'hFFFF;
      step(1'($urandom), 4'($urandom), 4'($urandom | $urandom),
           4'($urandom & $urandom), s, "");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule